// File: doc/BRIEF.md
# Iterative Multiply-Divide Unit with HI/LO Result Pair

This block performs integer multiplication and division for a processor datapath in signed and unsigned forms, sharing one sequencer. A caller pulses `start_i` with an operation code and two operands. The unit then raises `busy_o`, works for a fixed number of cycles and lowers `busy_o` once the results are in place. A full multiply leaves the upper half of the double-width product in HI and the lower half in LO. A divide leaves the quotient in LO and the remainder in HI. Both registers can be read at any time through `hi_o` and `lo_o`.

A third kind of operation, the low-product multiply, delivers only the lower word of the product on a separate result port and leaves HI and LO untouched. This lets a three-operand multiply run without disturbing a pending HI/LO pair. Multiplication uses shift-and-add and division uses a restoring loop. Each handles one operand bit per cycle on operand magnitudes, and a final cycle restores the signs.

Top module: `mdu_top`

## Requirements
- R1: Operation codes are 0 signed multiply, 1 unsigned multiply, 2 signed divide, 3 unsigned divide, 4 low-product multiply. A `start_i` seen while idle with a code from 0 to 4 raises `busy_o` on the next cycle. Codes 5 to 7 are ignored: `busy_o` stays low and HI, LO and the low-product result keep their values.
- R2: Every accepted operation keeps `busy_o` high for exactly WIDTH+1 consecutive cycles. The new HI/LO values, or the new low-product result, are visible in the first cycle with `busy_o` low.
- R3: Unsigned multiply places bits [2W-1:W] of the unsigned 2W-bit product in HI and bits [W-1:0] in LO.
- R4: Signed multiply places the two's-complement 2W-bit product in HI (upper half) and LO (lower half). No overflow indication exists for any multiply.
- R5: Unsigned divide by a nonzero divisor places the quotient in LO and the remainder in HI.
- R6: Signed divide by a nonzero divisor truncates the quotient toward zero. The remainder takes the sign of the dividend. The most negative dividend divided by -1 gives LO equal to the most negative value and HI equal to 0.
- R7: Divide by zero in either form completes with normal timing and no trap. LO becomes all ones and HI becomes the dividend unchanged.
- R8: Low-product multiply drives the lower W bits of the product on `mul_lo_o` and leaves HI and LO unchanged.
- R9: A `start_i` that arrives while `busy_o` is high is ignored. The running operation finishes with its original operands and timing.
- R10: Reset clears HI, LO and `mul_lo_o` to zero with `busy_o` low. Between operations HI and LO hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Starts an operation when the unit is idle |
| op_i | input | 3 | Operation code (see R1) |
| a_i | input | WIDTH | First operand: multiplicand or dividend |
| b_i | input | WIDTH | Second operand: multiplier or divisor |
| busy_o | output | 1 | High while an operation is running |
| hi_o | output | WIDTH | HI register: product upper half or remainder |
| lo_o | output | WIDTH | LO register: product lower half or quotient |
| mul_lo_o | output | WIDTH | Lower product word of the last low-product multiply |

## Verification
On every cycle the assertions check the control rules. `busy_o` rises only after a start. An undefined code never raises it. The latched operation cannot change mid-run. HI and LO move only at the cycle that ends an operation, and never at the end of a low-product multiply. The divide loop's partial remainder stays below the divisor. Whether the arithmetic is right (sign handling, truncation direction, the most-negative-by-minus-one case, the divide-by-zero values and the exact busy length) can only be shown by the bench. It sweeps every operand pair at a 4-bit width and runs directed 32-bit cases.

// File: rtl/mdu_pkg.sv
// Package: shared operation codes and sequencer states for the
// multiply-divide unit. Assumes a 3-bit operation code field.
package mdu_pkg;

    typedef enum logic [2:0] {
        OP_MUL_S  = 3'd0,
        OP_MUL_U  = 3'd1,
        OP_DIV_S  = 3'd2,
        OP_DIV_U  = 3'd3,
        OP_MUL_LO = 3'd4
    } mdu_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIX  = 2'd2
    } mdu_state_e;

    localparam logic [2:0] OP_LAST = 3'd4;

    // True for codes the unit accepts.
    function automatic logic op_is_valid(input logic [2:0] code);
        return code <= OP_LAST;
    endfunction

    // True for operations that treat operands as two's complement.
    function automatic logic op_is_signed(input logic [2:0] code);
        return (code == OP_MUL_S) || (code == OP_DIV_S);
    endfunction

    // True for the two divide operations.
    function automatic logic op_is_div(input logic [2:0] code);
        return (code == OP_DIV_S) || (code == OP_DIV_U);
    endfunction

endpackage

// File: rtl/mdu_operand_prep.sv
// Operand preparation: turns two operands into unsigned magnitudes plus
// sign flags. Purely combinational. Assumes WIDTH >= 2. When signed_i is
// low the operands pass through unchanged and both flags are zero.
module mdu_operand_prep #(
    parameter int WIDTH = 32
) (
    input  logic             signed_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] mag_a_o,
    output logic [WIDTH-1:0] mag_b_o,
    output logic             neg_a_o,
    output logic             neg_b_o
);

    // Sign detection and magnitude selection for both operands.
    always_comb begin
        neg_a_o = signed_i & a_i[WIDTH-1];
        neg_b_o = signed_i & b_i[WIDTH-1];
        mag_a_o = neg_a_o ? -a_i : a_i;
        mag_b_o = neg_b_o ? -b_i : b_i;
    end

endmodule

// File: rtl/mdu_mul_core.sv
// Shift-and-add multiplier on unsigned magnitudes, one multiplier bit per
// step. After WIDTH steps following a load, prod_o holds the 2*WIDTH-bit
// unsigned product. Assumes load_i and step_i are never high together.
module mdu_mul_core #(
    parameter int WIDTH = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load_i,
    input  logic               step_i,
    input  logic [WIDTH-1:0]   mag_a_i,
    input  logic [WIDTH-1:0]   mag_b_i,
    output logic [2*WIDTH-1:0] prod_o
);

    logic [WIDTH-1:0]   mcand_q;
    logic [2*WIDTH-1:0] acc_q;
    logic [WIDTH:0]     upper_sum;

    // Adds the multiplicand to the upper half when the current multiplier bit is set.
    always_comb begin
        upper_sum = {1'b0, acc_q[2*WIDTH-1:WIDTH]}
                  + (acc_q[0] ? {1'b0, mcand_q} : {(WIDTH+1){1'b0}});
    end

    // Loads the operands, then shifts the partial product right once per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mcand_q <= '0;
            acc_q   <= '0;
        end else if (load_i) begin
            mcand_q <= mag_a_i;
            acc_q   <= {{WIDTH{1'b0}}, mag_b_i};
        end else if (step_i) begin
            acc_q   <= {upper_sum, acc_q[WIDTH-1:1]};
        end
    end

    assign prod_o = acc_q;

endmodule

// File: rtl/mdu_div_core.sv
// Restoring divider on unsigned magnitudes, one quotient bit per step.
// After WIDTH steps following a load, quo_o and rem_o hold the unsigned
// quotient and remainder. With a zero divisor the values are not used.
module mdu_div_core #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             step_i,
    input  logic [WIDTH-1:0] mag_a_i,
    input  logic [WIDTH-1:0] mag_b_i,
    output logic [WIDTH-1:0] quo_o,
    output logic [WIDTH-1:0] rem_o
);

    logic [WIDTH-1:0] divisor_q;
    logic [WIDTH-1:0] quo_q;
    logic [WIDTH-1:0] rem_q;
    logic [WIDTH:0]   shifted;
    logic             fits;
    logic [WIDTH-1:0] diff;

    // Brings in the next dividend bit and trial-subtracts the divisor.
    always_comb begin
        shifted = {rem_q, quo_q[WIDTH-1]};
        fits    = shifted >= {1'b0, divisor_q};
        diff    = shifted[WIDTH-1:0] - divisor_q;
    end

    // Loads the operands, then records one quotient bit per step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            divisor_q <= '0;
            quo_q     <= '0;
            rem_q     <= '0;
        end else if (load_i) begin
            divisor_q <= mag_b_i;
            quo_q     <= mag_a_i;
            rem_q     <= '0;
        end else if (step_i) begin
            rem_q     <= fits ? diff : shifted[WIDTH-1:0];
            quo_q     <= {quo_q[WIDTH-2:0], fits};
        end
    end

    assign quo_o = quo_q;
    assign rem_o = rem_q;

    // The partial remainder stays below a nonzero divisor (supports R5, R6).
    assert_rem_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && divisor_q != '0) |=> (rem_q < divisor_q));

endmodule

// File: rtl/mdu_result_fix.sv
// Result correction: applies signs to the magnitude results and selects
// the divide-by-zero values. Combinational. Assumes the sign flags were
// produced for the same operation that op_i names.
module mdu_result_fix #(
    parameter int WIDTH = 32
) (
    input  mdu_pkg::mdu_op_e   op_i,
    input  logic               neg_a_i,
    input  logic               neg_b_i,
    input  logic               div_zero_i,
    input  logic [WIDTH-1:0]   dividend_i,
    input  logic [2*WIDTH-1:0] prod_i,
    input  logic [WIDTH-1:0]   quo_i,
    input  logic [WIDTH-1:0]   rem_i,
    output logic [WIDTH-1:0]   hi_o,
    output logic [WIDTH-1:0]   lo_o
);
    import mdu_pkg::*;

    logic [2*WIDTH-1:0] prod_fixed;
    logic [WIDTH-1:0]   quo_fixed;
    logic [WIDTH-1:0]   rem_fixed;
    logic               sgn;

    // Sign restoration for product, quotient (sign XOR) and remainder (dividend sign).
    always_comb begin
        sgn        = op_is_signed(op_i);
        prod_fixed = (sgn && (neg_a_i ^ neg_b_i)) ? -prod_i : prod_i;
        quo_fixed  = (sgn && (neg_a_i ^ neg_b_i)) ? -quo_i : quo_i;
        rem_fixed  = (sgn && neg_a_i) ? -rem_i : rem_i;
    end

    // Chooses the HI/LO pair by operation, with the divide-by-zero values.
    always_comb begin
        if (op_is_div(op_i)) begin
            if (div_zero_i) begin
                hi_o = dividend_i;
                lo_o = '1;
            end else begin
                hi_o = rem_fixed;
                lo_o = quo_fixed;
            end
        end else begin
            hi_o = prod_fixed[2*WIDTH-1:WIDTH];
            lo_o = prod_fixed[WIDTH-1:0];
        end
    end

endmodule

// File: rtl/mdu_top.sv
// Multiply-divide unit top: accepts one operation at a time, sequences the
// shared iterative cores for WIDTH steps plus one correction cycle, and
// keeps the HI/LO pair and the low-product result. Assumes a single clock
// and a synchronous active-low reset.
module mdu_top #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [2:0]       op_i,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic             busy_o,
    output logic [WIDTH-1:0] hi_o,
    output logic [WIDTH-1:0] lo_o,
    output logic [WIDTH-1:0] mul_lo_o
);
    import mdu_pkg::*;

    localparam int CW = $clog2(WIDTH + 1);
    localparam logic [CW-1:0] LAST_STEP = CW'(WIDTH - 1);

    mdu_state_e         state_q;
    logic [CW-1:0]      cnt_q;
    mdu_op_e            op_q;
    logic               neg_a_q;
    logic               neg_b_q;
    logic               div_zero_q;
    logic [WIDTH-1:0]   dividend_q;
    logic [WIDTH-1:0]   hi_q;
    logic [WIDTH-1:0]   lo_q;
    logic [WIDTH-1:0]   mul_lo_q;

    logic               accept;
    logic               running;
    logic [WIDTH-1:0]   mag_a;
    logic [WIDTH-1:0]   mag_b;
    logic               neg_a;
    logic               neg_b;
    logic [2*WIDTH-1:0] prod;
    logic [WIDTH-1:0]   quo;
    logic [WIDTH-1:0]   rem;
    logic [WIDTH-1:0]   hi_next;
    logic [WIDTH-1:0]   lo_next;

    // Start acceptance: idle and a defined code only.
    always_comb begin
        accept  = start_i && (state_q == ST_IDLE) && op_is_valid(op_i);
        running = (state_q == ST_RUN);
    end

    mdu_operand_prep #(.WIDTH(WIDTH)) u_prep (
        .signed_i (op_is_signed(op_i)),
        .a_i      (a_i),
        .b_i      (b_i),
        .mag_a_o  (mag_a),
        .mag_b_o  (mag_b),
        .neg_a_o  (neg_a),
        .neg_b_o  (neg_b)
    );

    mdu_mul_core #(.WIDTH(WIDTH)) u_mul (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (accept && !op_is_div(op_i)),
        .step_i  (running && !op_is_div(op_q)),
        .mag_a_i (mag_a),
        .mag_b_i (mag_b),
        .prod_o  (prod)
    );

    mdu_div_core #(.WIDTH(WIDTH)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (accept && op_is_div(op_i)),
        .step_i  (running && op_is_div(op_q)),
        .mag_a_i (mag_a),
        .mag_b_i (mag_b),
        .quo_o   (quo),
        .rem_o   (rem)
    );

    mdu_result_fix #(.WIDTH(WIDTH)) u_fix (
        .op_i       (op_q),
        .neg_a_i    (neg_a_q),
        .neg_b_i    (neg_b_q),
        .div_zero_i (div_zero_q),
        .dividend_i (dividend_q),
        .prod_i     (prod),
        .quo_i      (quo),
        .rem_i      (rem),
        .hi_o       (hi_next),
        .lo_o       (lo_next)
    );

    // Sequencer: idle, WIDTH run steps, one correction cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) begin
                    state_q <= ST_RUN;
                    cnt_q   <= '0;
                end
                ST_RUN: begin
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == LAST_STEP) state_q <= ST_FIX;
                end
                ST_FIX:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Operation context captured at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q       <= OP_MUL_S;
            neg_a_q    <= 1'b0;
            neg_b_q    <= 1'b0;
            div_zero_q <= 1'b0;
            dividend_q <= '0;
        end else if (accept) begin
            op_q       <= mdu_op_e'(op_i);
            neg_a_q    <= neg_a;
            neg_b_q    <= neg_b;
            div_zero_q <= (b_i == '0);
            dividend_q <= a_i;
        end
    end

    // Result registers, written only in the correction cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q     <= '0;
            lo_q     <= '0;
            mul_lo_q <= '0;
        end else if (state_q == ST_FIX) begin
            if (op_q == OP_MUL_LO) begin
                mul_lo_q <= lo_next;
            end else begin
                hi_q <= hi_next;
                lo_q <= lo_next;
            end
        end
    end

    assign busy_o   = (state_q != ST_IDLE);
    assign hi_o     = hi_q;
    assign lo_o     = lo_q;
    assign mul_lo_o = mul_lo_q;

    // Busy only rises in response to a start request.
    assert_busy_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    // An undefined code seen while idle never starts an operation.
    assert_bad_code_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && (op_i > OP_LAST)) |=> !busy_o);

    // The latched operation cannot change while the unit stays busy.
    assert_op_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> $stable(op_q));

    // HI and LO change only at the cycle an operation ends.
    assert_hilo_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(busy_o) |-> ($stable(hi_o) && $stable(lo_o)));

    // A low-product multiply ends without touching HI or LO.
    assert_mullo_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(busy_o) && op_q == OP_MUL_LO) |-> ($stable(hi_o) && $stable(lo_o)));

endmodule

// File: tb/test_mdu_top.sv
module test_mdu_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    // Narrow instance (exhaustive sweep) signals.
    logic       n_start = 1'b0;
    logic [2:0] n_op = 3'd0;
    logic [3:0] n_a = '0, n_b = '0;
    logic       n_busy;
    logic [3:0] n_hi, n_lo, n_ml;

    // Wide instance (directed cases) signals.
    logic        w_start = 1'b0;
    logic [2:0]  w_op = 3'd0;
    logic [31:0] w_a = '0, w_b = '0;
    logic        w_busy;
    logic [31:0] w_hi, w_lo, w_ml;

    mdu_top #(.WIDTH(4)) i_mdu_top (
        .clk(clk), .rst_n(rst_n), .start_i(n_start), .op_i(n_op),
        .a_i(n_a), .b_i(n_b), .busy_o(n_busy), .hi_o(n_hi), .lo_o(n_lo),
        .mul_lo_o(n_ml)
    );

    mdu_top #(.WIDTH(32)) i_mdu_top_wide (
        .clk(clk), .rst_n(rst_n), .start_i(w_start), .op_i(w_op),
        .a_i(w_a), .b_i(w_b), .busy_o(w_busy), .hi_o(w_hi), .lo_o(w_lo),
        .mul_lo_o(w_ml)
    );

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Arithmetic model: hi/lo for ops 0..3, low product in lo for op 4.
    task automatic model(input int w, input int op, input logic [63:0] a,
                         input logic [63:0] b, output logic [63:0] hi,
                         output logic [63:0] lo);
        logic [63:0] mask = (64'd1 << w) - 64'd1;
        longint sa = a[w-1] ? longint'(a) - (longint'(1) << w) : longint'(a);
        longint sb = b[w-1] ? longint'(b) - (longint'(1) << w) : longint'(b);
        logic [63:0] p;
        case (op)
            0: p = 64'(sa * sb);
            1, 4: p = a * b;
            default: p = '0;
        endcase
        if (op == 2 || op == 3) begin
            if (b == 0) begin
                hi = a; lo = mask;
            end else if (op == 2) begin
                hi = 64'(sa % sb) & mask; lo = 64'(sa / sb) & mask;
            end else begin
                hi = (a % b) & mask; lo = (a / b) & mask;
            end
        end else begin
            hi = (p >> w) & mask;
            lo = p & mask;
        end
    endtask

    function automatic string tag_of(input int op, input logic [63:0] b);
        case (op)
            0: return "R4";
            1: return "R3";
            2: return (b == 0) ? "R7" : "R6";
            3: return (b == 0) ? "R7" : "R5";
            default: return "R8";
        endcase
    endfunction

    task automatic run_n(input int op, input logic [3:0] a, input logic [3:0] b, output int cyc);
        @(negedge clk);
        n_start = 1'b1; n_op = 3'(op); n_a = a; n_b = b;
        @(negedge clk);
        n_start = 1'b0;
        cyc = 0;
        while (n_busy && cyc < 100) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic run_w(input int op, input logic [31:0] a, input logic [31:0] b, output int cyc);
        @(negedge clk);
        w_start = 1'b1; w_op = 3'(op); w_a = a; w_b = b;
        @(negedge clk);
        w_start = 1'b0;
        cyc = 0;
        while (w_busy && cyc < 100) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic check_result(input int w, input int op, input logic [63:0] a,
                                input logic [63:0] b, input int cyc,
                                input logic [63:0] hi, input logic [63:0] lo,
                                input logic [63:0] ml, input logic [63:0] hi0,
                                input logic [63:0] lo0);
        logic [63:0] eh, el;
        model(w, op, a, b, eh, el);
        chk("R2 busy length", 64'(cyc), 64'(w + 1));
        if (op == 4) begin
            chk("R8 low product", ml, el);
            chk("R8 hi kept", hi, hi0);
            chk("R8 lo kept", lo, lo0);
        end else begin
            chk(tag_of(op, b), hi, eh);
            chk(tag_of(op, b), lo, el);
        end
    endtask

    initial begin
        int cyc;
        logic [3:0] h0, l0, m0;
        logic [31:0] wa [10];
        logic [31:0] wb [10];
        int wo [10];

        repeat (3) @(negedge clk);
        // R10: reset state.
        chk("R10 busy", 64'(n_busy), 0);
        chk("R10 hi", 64'(n_hi), 0);
        chk("R10 lo", 64'(n_lo), 0);
        chk("R10 mul_lo", 64'(n_ml), 0);
        chk("R10 wide hi", 64'(w_hi), 0);
        rst_n = 1'b1;

        // R3 R4 R5 R6 R7 R8: exhaustive sweep at 4 bits.
        for (int op = 0; op < 5; op++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++) begin
                    h0 = n_hi; l0 = n_lo;
                    run_n(op, 4'(a), 4'(b), cyc);
                    check_result(4, op, 64'(a), 64'(b), cyc, 64'(n_hi), 64'(n_lo),
                                 64'(n_ml), 64'(h0), 64'(l0));
                end

        // R1: undefined codes are ignored.
        for (int op = 5; op < 8; op++) begin
            h0 = n_hi; l0 = n_lo; m0 = n_ml;
            @(negedge clk);
            n_start = 1'b1; n_op = 3'(op); n_a = 4'd7; n_b = 4'd3;
            @(negedge clk);
            n_start = 1'b0;
            chk("R1 bad code busy", 64'(n_busy), 0);
            @(negedge clk);
            chk("R1 bad code hi", 64'(n_hi), 64'(h0));
            chk("R1 bad code lo", 64'(n_lo), 64'(l0));
            chk("R1 bad code mul_lo", 64'(n_ml), 64'(m0));
        end

        // R1 R9: start while busy is ignored; original operands complete.
        @(negedge clk);
        n_start = 1'b1; n_op = 3'd1; n_a = 4'd3; n_b = 4'd5;
        @(negedge clk);
        chk("R1 busy after start", 64'(n_busy), 1);
        n_op = 3'd0; n_a = 4'd15; n_b = 4'd15;
        @(negedge clk);
        n_start = 1'b0;
        cyc = 1;
        while (n_busy && cyc < 100) begin
            cyc++;
            @(negedge clk);
        end
        chk("R9 busy length", 64'(cyc), 5);
        chk("R9 hi", 64'(n_hi), 0);
        chk("R9 lo", 64'(n_lo), 64'hF);
        // R10: values hold between operations.
        repeat (8) @(negedge clk);
        chk("R10 hold hi", 64'(n_hi), 0);
        chk("R10 hold lo", 64'(n_lo), 64'hF);
        chk("R9 not restarted", 64'(n_busy), 0);

        // Directed 32-bit cases.
        wo[0] = 0; wa[0] = 32'h8000_0000; wb[0] = 32'h8000_0000;
        wo[1] = 1; wa[1] = 32'hFFFF_FFFF; wb[1] = 32'hFFFF_FFFF;
        wo[2] = 0; wa[2] = 32'hFFFF_FFFD; wb[2] = 32'd7;
        wo[3] = 2; wa[3] = 32'hFFFF_FFF9; wb[3] = 32'd2;
        wo[4] = 2; wa[4] = 32'd7;         wb[4] = 32'hFFFF_FFFE;
        wo[5] = 2; wa[5] = 32'h8000_0000; wb[5] = 32'hFFFF_FFFF;
        wo[6] = 3; wa[6] = 32'hFFFF_FFFF; wb[6] = 32'h10;
        wo[7] = 3; wa[7] = 32'd123;       wb[7] = 32'd0;
        wo[8] = 2; wa[8] = 32'hFFFF_FFFB; wb[8] = 32'd0;
        wo[9] = 4; wa[9] = 32'h1234_5678; wb[9] = 32'h9ABC_DEF0;
        for (int i = 0; i < 10; i++) begin
            logic [31:0] hh, ll;
            hh = w_hi; ll = w_lo;
            run_w(wo[i], wa[i], wb[i], cyc);
            check_result(32, wo[i], 64'(wa[i]), 64'(wb[i]), cyc, 64'(w_hi),
                         64'(w_lo), 64'(w_ml), 64'(hh), 64'(ll));
        end

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule